// File: doc/BRIEF.md
# DTMF Dual-Tone Sample Generator

This block turns a 4-bit digit code and a transmit enable into a stream of signed digital samples that carry the matching DTMF tone pair. It has two phase-accumulator oscillators, one for the row (low) group and one for the column (high) group. Each oscillator feeds a sine-shaped waveform approximation scaled to its own fixed amplitude. A summing stage adds the two waves and saturates the result.

A free-running divider makes a sample strobe from the system clock. The nominal clock is 3.579545 MHz and the nominal sample rate is 8 kHz. Each oscillator step, and each output sample, happens on that strobe. While the enable is low the output sits at mid-scale (zero). When the enable rises, the code is captured, both oscillators restart from phase zero, and a new sample is produced on every strobe until the enable drops.

Phase increments are computed at elaboration from the clock, the sample rate and the accumulator width. The downstream D/A converter and analog shaping are outside the block.

Top module: `dtmf_tone_gen`

## Requirements
- R1: While `tx_en` is low, `sample_out` is 0 and `sample_valid` is 0 from the clock edge after `tx_en` is seen low.
- R2: The code on `tx_code` is captured at the first clock edge where `tx_en` is high after being low or after reset. Changes to `tx_code` during a burst do not alter the output.
- R3: The code map (code: row Hz / column Hz) is as follows:
  - 0001: 697/1209, 0010: 697/1336, 0011: 697/1477
  - 0100: 770/1209, 0101: 770/1336, 0110: 770/1477
  - 0111: 852/1209, 1000: 852/1336, 1001: 852/1477
  - 1010 ('0'): 941/1336, 1011 ('*'): 941/1209, 1100 ('#'): 941/1477
  - 1101 (A): 697/1633, 1110 (B): 770/1633, 1111 (C): 852/1633, 0000 (D): 941/1633
- R4: Each phase increment is round(f * 2^PHASE_W * DIV / CLK_HZ), with DIV = floor(CLK_HZ / SAMPLE_HZ). The resulting tone frequency is within 1.5 % of nominal.
- R5: Both accumulators start at zero on capture. The k-th valid sample of a burst (k from 0) uses phases k*inc mod 2^PHASE_W.
- R6: The column amplitude is `HI_AMP`. The row amplitude is floor(HI_AMP*202/256), which is about 2.06 dB below the column amplitude, inside a 1 to 3 dB window.
- R7: Each oscillator's value is formed from its top 10 phase bits. Bit 9 gives the sign (1 = negative), and with x = bits 8:0 the magnitude is floor(A*x*(512-x)/65536).
- R8: The sum of the two oscillator values saturates to ±(2^(OUT_W-1)-1), so the most negative code never appears.
- R9: While a burst runs, `sample_valid` pulses for one cycle every DIV clock cycles.
- R10: A synchronous `srst` clears the captured code, the running state and the output. If `tx_en` is still high when reset is released, the current code is captured anew from phase zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high (power-down) |
| tx_code | input | 4 | Digit code to transmit |
| tx_en | input | 1 | Transmit enable |
| sample_out | output | OUT_W | Signed tone sample, 0 when idle |
| sample_valid | output | 1 | One-cycle pulse when a new sample is presented |

## Verification
The assertions check these properties on every cycle:
- the output falls to zero one edge after the enable is low;
- the captured code stays put while a burst runs;
- an accumulator is zero after a restart;
- each oscillator's value stays inside its amplitude;
- the strobe never lasts two cycles;
- the saturated sum never reaches the most negative code.

The correctness of the frequencies, the digit map, the phase-zero start, the amplitude ratio and the saturation values can only be shown by the bench's scenarios. These compare every sample of directed and random bursts, including mid-burst code changes and a reset during a burst, against an independently computed waveform. A second instance with a larger amplitude drives the sum into saturation.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int SHAPE_W = 10;

  // Row (low group) frequency for a row index.
  function automatic int row_hz(input int idx);
    case (idx)
      0: return 697;
      1: return 770;
      2: return 852;
      default: return 941;
    endcase
  endfunction

  // Column (high group) frequency for a column index.
  function automatic int col_hz(input int idx);
    case (idx)
      0: return 1209;
      1: return 1336;
      2: return 1477;
      default: return 1633;
    endcase
  endfunction

  // Row index chosen by a digit code.
  function automatic logic [1:0] row_of(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13: return 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14: return 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15: return 2'd2;
      default:                 return 2'd3;
    endcase
  endfunction

  // Column index chosen by a digit code.
  function automatic logic [1:0] col_of(input logic [3:0] code);
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11: return 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10: return 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12: return 2'd2;
      default:                 return 2'd3;
    endcase
  endfunction

  // Rounded phase step per sample strobe.
  function automatic longint unsigned phase_inc(input int hz, input int clk_hz,
                                                input int div, input int pw);
    longint unsigned num;
    num = (longint'(hz) << pw) * longint'(div) + longint'(clk_hz / 2);
    return num / longint'(clk_hz);
  endfunction

  // Parabolic half-wave shape of amplitude amp from the top phase bits.
  function automatic int tone_shape(input int amp, input logic [SHAPE_W-1:0] u);
    int x;
    int mag;
    x   = int'(u[SHAPE_W-2:0]);
    mag = (amp * (x * (512 - x))) >>> 16;
    return u[SHAPE_W-1] ? -mag : mag;
  endfunction

  // Symmetric saturation to a signed width.
  function automatic int clip_sym(input int v, input int w);
    int lim;
    lim = (1 << (w - 1)) - 1;
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/dtmf_rate_div.sv
module dtmf_rate_div #(
  parameter int DIV = 447
) (
  input  logic clk,
  input  logic srst,
  output logic stb_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (srst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o = (cnt_q == LAST);

  // R9: a strobe lasts one cycle only
  p_stb_single_r9: assert property (@(posedge clk) disable iff (srst)
    stb_o |=> !stb_o);

endmodule

// File: rtl/dtmf_osc.sv
module dtmf_osc #(
  parameter int PHASE_W = 24,
  parameter int OUT_W   = 12,
  parameter int AMP     = 1100
) (
  input  logic                     clk,
  input  logic                     srst,
  input  logic                     restart,
  input  logic                     advance,
  input  logic [PHASE_W-1:0]       inc,
  output logic signed [OUT_W-1:0]  wave_o
);
  localparam int SW = dtmf_pkg::SHAPE_W;

  logic [PHASE_W-1:0] phase_q;
  logic [SW-1:0]      tap;

  always_ff @(posedge clk) begin
    if (srst || restart) phase_q <= '0;
    else if (advance)    phase_q <= phase_q + inc;
  end

  assign tap    = phase_q[PHASE_W-1 -: SW];
  assign wave_o = OUT_W'(dtmf_pkg::tone_shape(AMP, tap));

  // R5: a restart leaves the accumulator at zero
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (srst)
    restart |=> (phase_q == '0));

  // R7: the shaped value stays inside the amplitude
  p_amp_bound_r7: assert property (@(posedge clk) disable iff (srst)
    (int'(wave_o) <= AMP) && (int'(wave_o) >= -AMP));

endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen #(
  parameter int CLK_HZ    = 3579545,
  parameter int SAMPLE_HZ = 8000,
  parameter int PHASE_W   = 24,
  parameter int OUT_W     = 12,
  parameter int HI_AMP    = 1100
) (
  input  logic                    clk,
  input  logic                    srst,
  input  logic [3:0]              tx_code,
  input  logic                    tx_en,
  output logic signed [OUT_W-1:0] sample_out,
  output logic                    sample_valid
);
  localparam int DIV    = CLK_HZ / SAMPLE_HZ;
  localparam int LO_AMP = (HI_AMP * 202) / 256;
  localparam int NGRP   = 2;
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic             stb;
  logic             active_q;
  logic [3:0]       code_q;
  logic [PHASE_W-1:0] row_inc [4];
  logic [PHASE_W-1:0] col_inc [4];
  logic [PHASE_W-1:0] grp_inc [NGRP];
  logic signed [OUT_W-1:0] grp_wave [NGRP];
  logic             osc_restart;
  logic             osc_advance;
  int               sum_raw;

  dtmf_rate_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .srst  (srst),
    .stb_o (stb)
  );

  for (genvar i = 0; i < 4; i++) begin : g_inc_tab
    assign row_inc[i] = PHASE_W'(dtmf_pkg::phase_inc(dtmf_pkg::row_hz(i), CLK_HZ, DIV, PHASE_W));
    assign col_inc[i] = PHASE_W'(dtmf_pkg::phase_inc(dtmf_pkg::col_hz(i), CLK_HZ, DIV, PHASE_W));
  end

  assign grp_inc[0]  = row_inc[dtmf_pkg::row_of(code_q)];
  assign grp_inc[1]  = col_inc[dtmf_pkg::col_of(code_q)];
  assign osc_restart = !active_q;
  assign osc_advance = active_q && tx_en && stb;

  for (genvar g = 0; g < NGRP; g++) begin : g_osc
    dtmf_osc #(
      .PHASE_W (PHASE_W),
      .OUT_W   (OUT_W),
      .AMP     ((g == 0) ? LO_AMP : HI_AMP)
    ) u_osc (
      .clk     (clk),
      .srst    (srst),
      .restart (osc_restart),
      .advance (osc_advance),
      .inc     (grp_inc[g]),
      .wave_o  (grp_wave[g])
    );
  end

  assign sum_raw = int'(grp_wave[0]) + int'(grp_wave[1]);

  always_ff @(posedge clk) begin
    if (srst) begin
      active_q     <= 1'b0;
      code_q       <= 4'd0;
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else if (!tx_en) begin
      active_q     <= 1'b0;
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else if (!active_q) begin
      active_q     <= 1'b1;
      code_q       <= tx_code;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= stb;
      if (stb) sample_out <= OUT_W'(dtmf_pkg::clip_sym(sum_raw, OUT_W));
    end
  end

  // R1: a low enable forces the idle level on the next edge
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (srst)
    !tx_en |=> (sample_out == '0) && !sample_valid);

  // R2: the captured code stays put during a burst
  p_code_hold_r2: assert property (@(posedge clk) disable iff (srst)
    active_q |=> $stable(code_q));

  // R8: saturation never yields the most negative code
  p_clip_sym_r8: assert property (@(posedge clk) disable iff (srst)
    sample_valid |-> (sample_out != MOST_NEG));

endmodule

// File: tb/sim_dtmf_tone_gen.sv
module sim_dtmf_tone_gen;
  localparam int CLK_HZ = 80000;
  localparam int SR     = 8000;
  localparam int DIV    = 10;
  localparam int PW     = 24;
  localparam int OW     = 12;
  localparam int HI0    = 1100;
  localparam int HI1    = 1400;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic tx_en = 1'b0;
  logic [3:0] tx_code = 4'd0;
  logic signed [OW-1:0] s0, s1;
  logic v0, v1;
  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtmf_tone_gen #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SR), .PHASE_W(PW), .OUT_W(OW), .HI_AMP(HI0)) u0 (
    .clk(clk), .srst(srst), .tx_code(tx_code), .tx_en(tx_en), .sample_out(s0), .sample_valid(v0));
  dtmf_tone_gen #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SR), .PHASE_W(PW), .OUT_W(OW), .HI_AMP(HI1)) u1 (
    .clk(clk), .srst(srst), .tx_code(tx_code), .tx_en(tx_en), .sample_out(s1), .sample_valid(v1));

  function automatic int lo_hz_of(input int c);
    case (c)
      1, 2, 3, 13: return 697;
      4, 5, 6, 14: return 770;
      7, 8, 9, 15: return 852;
      default:     return 941;
    endcase
  endfunction

  function automatic int hi_hz_of(input int c);
    case (c)
      1, 4, 7, 11: return 1209;
      2, 5, 8, 10: return 1336;
      3, 6, 9, 12: return 1477;
      default:     return 1633;
    endcase
  endfunction

  function automatic longint b_inc(input int hz);
    real r;
    r = real'(hz) * 16777216.0 * real'(DIV) / real'(CLK_HZ);
    return longint'($rtoi(r + 0.5));
  endfunction

  function automatic int b_shape(input int amp, input longint ph);
    int idx;
    int x;
    int mag;
    idx = int'((ph / 16384) % 1024);
    x   = idx % 512;
    mag = (amp * x * (512 - x)) / 65536;
    return (idx >= 512) ? -mag : mag;
  endfunction

  function automatic int b_expect(input int c, input int k, input int hi);
    longint pl, ph;
    int lo, sum, lim;
    lo  = (hi * 202) / 256;
    pl  = (longint'(k) * b_inc(lo_hz_of(c))) % 64'd16777216;
    ph  = (longint'(k) * b_inc(hi_hz_of(c))) % 64'd16777216;
    sum = b_shape(lo, pl) + b_shape(hi, ph);
    lim = (1 << (OW - 1)) - 1;
    if (sum > lim)  sum = lim;
    if (sum < -lim) sum = -lim;
    return sum;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic collect(input int cap, input int n, input bit change_mid, input string req);
    int k = 0;
    longint last = 0;
    while (k < n) begin
      @(negedge clk);
      if (change_mid && k == 3) tx_code = 4'($urandom);
      if (v0) begin
        chk(int'(s0) == b_expect(cap, k, HI0), req, s0, b_expect(cap, k, HI0));
        chk(v1 && int'(s1) == b_expect(cap, k, HI1), "R8", s1, b_expect(cap, k, HI1));
        if (k > 0) chk(cyc - last == DIV, "R9", cyc - last, DIV);
        last = cyc;
        k++;
      end
    end
  endtask

  task automatic stop_idle();
    tx_en = 1'b0;
    @(negedge clk);
    chk(s0 == 0 && !v0 && s1 == 0 && !v1, "R1", s0, 0);
  endtask

  task automatic burst(input int c, input int n, input bit change_mid, input string req);
    @(negedge clk);
    tx_code = 4'(c);
    tx_en   = 1'b1;
    collect(c, n, change_mid, req);
    stop_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    real ratio_db;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    chk(s0 == 0 && !v0, "R10", s0, 0);
    srst = 1'b0;

    // R1: idle enable produces no samples
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i % 10 == 9) chk(s0 == 0 && !v0, "R1", s0, 0);
    end

    // R4: increments hold each tone within 1.5 %
    for (int i = 0; i < 8; i++) begin
      int hz;
      real fa;
      hz = (i < 4) ? lo_hz_of(i == 0 ? 1 : (i == 1 ? 4 : (i == 2 ? 7 : 0)))
                   : hi_hz_of(i == 4 ? 1 : (i == 5 ? 2 : (i == 6 ? 3 : 0)));
      fa = real'(b_inc(hz)) * real'(CLK_HZ) / real'(DIV) / 16777216.0;
      chk(fa > 0.985 * hz && fa < 1.015 * hz, "R4", $rtoi(fa), hz);
    end

    // R6: column to row amplitude ratio in the 1..3 dB window
    ratio_db = 20.0 * $ln(real'(HI0) / real'((HI0 * 202) / 256)) / $ln(10.0);
    chk(ratio_db > 1.0 && ratio_db < 3.0, "R6", $rtoi(ratio_db * 100.0), 200);

    // R3: every code of the map
    for (int c = 0; c < 16; c++) burst(c, 6, 1'b0, "R3");

    // R2: code changes in the middle of a burst are ignored
    for (int i = 0; i < 4; i++) burst(i * 4 + 2, 12, 1'b1, "R2");

    // R10: reset during a burst re-captures from phase zero
    @(negedge clk);
    tx_code = 4'd5;
    tx_en   = 1'b1;
    collect(5, 4, 1'b0, "R5");
    tx_code = 4'hA;
    srst    = 1'b1;
    @(negedge clk);
    chk(s0 == 0 && !v0, "R10", s0, 0);
    srst = 1'b0;
    collect(10, 8, 1'b0, "R10");
    stop_idle();

    // R5 / R7: random bursts, compared sample by sample
    for (int i = 0; i < 12; i++) begin
      int c, n;
      c = int'($urandom % 16);
      n = 5 + int'($urandom % 36);
      burst(c, n, i[0], "R7");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule